// File: doc/BRIEF.md
# Indexed Memory-Block Access Protection Table

This block holds access protection state for a 2 Mbyte shared memory, divided into 32 blocks of 64 Kbytes. Each block has three flags: read inhibit, write inhibit and lock. The host reaches the flags through two byte-wide indexed registers. Register 0 covers blocks 0 to 15. Register 1 covers blocks 16 to 31. Each register keeps its own 4-bit pointer. A write can move the pointer and update the flags of the newly selected block in the same edge. A write can also move only the pointer.

A combinational checker judges each host access. It takes an address in core address space, a read and/or write request, and two core override inputs. It returns one allow bit. The block number is taken from address bits [20:16]. Once a block's lock flag is set, that block's flags are frozen until the next hardware reset.

Top module: `blk_prot_table`

## Requirements
- R1: After reset, every block has read inhibit 0, write inhibit 1 and lock 0, and both register pointers are 0.
- R2: `reg_sel_i` = 0 selects the register for blocks 0–15, and 1 selects the register for blocks 16–31. A read returns {pointer[3:0], 0, lock, write inhibit, read inhibit} for block sel*16+pointer.
- R3: A write with bit 3 = 0 stores bits 7–4 as the pointer. In the same clock edge, it writes bits 0 (read inhibit), 1 (write inhibit) and 2 (lock) into the block selected by that new pointer.
- R4: A write with bit 3 = 1 updates only the pointer. No block flag changes.
- R5: Bit 3 of the read data is always 0.
- R6: While a block's lock flag is 1, no register write changes any of its three flags. Only reset clears the lock.
- R7: The two registers keep separate pointers. A write to one register leaves the other register's pointer unchanged.
- R8: For addresses below 2 Mbyte, the block is `acc_addr_i[20:16]`. A read is permitted when read inhibit is 0 and `core_rd_deny_i` is 0. A write is permitted when write inhibit is 0 and `core_wr_deny_i` is 0. `acc_allow_o` is 1 only if at least one request is raised and every raised request is permitted.
- R9: Any address at or above 2 Mbyte (any bit above bit 20 set) gives `acc_allow_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select (0: blocks 0–15, 1: blocks 16–31) |
| reg_wdata_i | input | 8 | Register write byte |
| reg_rdata_o | output | 8 | Read byte of the selected register |
| acc_addr_i | input | 24 | Host access address, core address space |
| acc_rd_i | input | 1 | Read request |
| acc_wr_i | input | 1 | Write (program/erase) request |
| core_rd_deny_i | input | 1 | Core override denying reads |
| core_wr_deny_i | input | 1 | Core override denying writes |
| acc_allow_o | output | 1 | Access permitted |

## Verification
A corrupted pointer or flag shows up on the very next register read, because the read byte is combinational from the stored state. It also shows up at once on `acc_allow_o` for any access that lands on the affected block. The bench compares both outputs with a behavioural model on every cycle, so a bad flag update is reported no later than the first cycle that selects or addresses that block. Lock misbehaviour shows up as a flag that changes after the lock was set, or as a lock that survives reset.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef struct packed {
    logic lk;
    logic wp;
    logic rp;
  } blk_flags_t;

  localparam blk_flags_t FLAGS_RST = '{lk: 1'b0, wp: 1'b1, rp: 1'b0};
  localparam int IDX_ONLY_BIT = 3;
endpackage

// File: rtl/prot_bank.sv
module prot_bank
  import prot_pkg::*;
#(
  parameter int IDX_W = 4,
  localparam int NBLK = 1 << IDX_W,
  localparam int REG_W = IDX_W + 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [REG_W-1:0]      wdata_i,
  output logic [REG_W-1:0]      rdata_o,
  output blk_flags_t [NBLK-1:0] flags_o
);
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] new_idx;
  logic             idx_only;
  blk_flags_t       new_flags;

  assign new_idx   = wdata_i[REG_W-1 -: IDX_W];
  assign idx_only  = wdata_i[IDX_ONLY_BIT];
  assign new_flags = blk_flags_t'(wdata_i[2:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   idx_q <= '0;
    else if (we_i) idx_q <= new_idx;
  end

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    logic hit;
    // flags go to the block named by the index carried in the same write
    assign hit = we_i && !idx_only && (new_idx == IDX_W'(g)) && !flags_o[g].lk;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  flags_o[g] <= FLAGS_RST;
      else if (hit) flags_o[g] <= new_flags;
    end
  end

  assign rdata_o = {idx_q, 1'b0, flags_o[idx_q]};
endmodule

// File: rtl/prot_check.sv
module prot_check
  import prot_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int BLK_SHIFT = 16,
  parameter int BLK_W     = 5,
  localparam int NUM_BLKS = 1 << BLK_W,
  localparam int TOP      = BLK_SHIFT + BLK_W
) (
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      rd_i,
  input  logic                      wr_i,
  input  logic                      core_rd_deny_i,
  input  logic                      core_wr_deny_i,
  input  blk_flags_t [NUM_BLKS-1:0] flags_i,
  output logic                      allow_o
);
  logic [BLK_W-1:0] blk;
  logic             in_range;
  blk_flags_t       f;
  logic             rd_ok, wr_ok;

  assign blk = addr_i[TOP-1:BLK_SHIFT];

  if (ADDR_W > TOP) begin : g_hi
    assign in_range = (addr_i[ADDR_W-1:TOP] == '0);
  end else begin : g_nohi
    assign in_range = 1'b1;
  end

  assign f       = flags_i[blk];
  assign rd_ok   = !f.rp && !core_rd_deny_i;
  assign wr_ok   = !f.wp && !core_wr_deny_i;
  assign allow_o = in_range && (rd_i || wr_i) && (!rd_i || rd_ok) && (!wr_i || wr_ok);
endmodule

// File: rtl/blk_prot_table.sv
module blk_prot_table
  import prot_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int IDX_W     = 4,
  parameter int BLK_SHIFT = 16,
  parameter int ADDR_W    = 24,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int REG_W    = IDX_W + 4,
  localparam int PER_BANK = 1 << IDX_W,
  localparam int NUM_BLKS = NUM_BANKS * PER_BANK,
  localparam int BLK_W    = $clog2(NUM_BLKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [BANK_W-1:0] reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_rd_i,
  input  logic              acc_wr_i,
  input  logic              core_rd_deny_i,
  input  logic              core_wr_deny_i,
  output logic              acc_allow_o
);
  blk_flags_t [NUM_BLKS-1:0] flags_q;
  logic [NUM_BANKS-1:0][REG_W-1:0] bank_rdata;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    blk_flags_t [PER_BANK-1:0] bflags;
    prot_bank #(.IDX_W(IDX_W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (reg_we_i && (reg_sel_i == BANK_W'(b))),
      .wdata_i(reg_wdata_i),
      .rdata_o(bank_rdata[b]),
      .flags_o(bflags)
    );
    assign flags_q[b*PER_BANK +: PER_BANK] = bflags;
  end

  assign reg_rdata_o = bank_rdata[reg_sel_i];

  prot_check #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .BLK_W(BLK_W)) u_check (
    .addr_i        (acc_addr_i),
    .rd_i          (acc_rd_i),
    .wr_i          (acc_wr_i),
    .core_rd_deny_i(core_rd_deny_i),
    .core_wr_deny_i(core_wr_deny_i),
    .flags_i       (flags_q),
    .allow_o       (acc_allow_o)
  );
endmodule

// File: rtl/prot_table_sva.sv
module prot_table_sva #(
  parameter int NUM_BLKS = 32,
  parameter int BANK_W   = 1,
  parameter int REG_W    = 8,
  parameter int ADDR_W   = 24,
  parameter int TOP      = 21
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  reg_we_i,
  input logic [BANK_W-1:0]     reg_sel_i,
  input logic [REG_W-1:0]      reg_wdata_i,
  input logic [REG_W-1:0]      reg_rdata_o,
  input logic [ADDR_W-1:0]     acc_addr_i,
  input logic                  acc_rd_i,
  input logic                  acc_wr_i,
  input logic                  core_rd_deny_i,
  input logic                  core_wr_deny_i,
  input logic                  acc_allow_o,
  input logic [NUM_BLKS*3-1:0] flags_q
);
  p_idx_stored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> (reg_sel_i != $past(reg_sel_i)) ||
                 (reg_rdata_o[REG_W-1:4] == $past(reg_wdata_i[REG_W-1:4])));

  p_idx_only_keeps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_wdata_i[3]) |=> $stable(flags_q));

  p_no_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_rd_i && !acc_wr_i) |-> !acc_allow_o);

  p_core_rd_deny_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_rd_i && core_rd_deny_i) |-> !acc_allow_o);

  p_core_wr_deny_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr_i && core_wr_deny_i) |-> !acc_allow_o);

  if (ADDR_W > TOP) begin : g_oor
    p_oor_deny_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_addr_i[ADDR_W-1:TOP] != '0) |-> !acc_allow_o);
  end

  for (genvar k = 0; k < NUM_BLKS; k++) begin : g_lk
    p_lock_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flags_q[3*k+2] |=> $stable(flags_q[3*k+2 -: 3]));
  end
endmodule

bind blk_prot_table prot_table_sva #(
  .NUM_BLKS(NUM_BLKS), .BANK_W(BANK_W), .REG_W(REG_W),
  .ADDR_W(ADDR_W), .TOP(BLK_SHIFT + BLK_W)
) u_sva (.*);

// File: tb/blk_prot_table_bench.sv
module blk_prot_table_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [0:0]  reg_sel_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic [23:0] acc_addr_i = '0;
  logic        acc_rd_i = 1'b0, acc_wr_i = 1'b0;
  logic        core_rd_deny_i = 1'b0, core_wr_deny_i = 1'b0;
  logic        acc_allow_o;

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural reference
  bit m_rp[32], m_wp[32], m_lk[32];
  int m_idx[2];

  always #4 clk_i = ~clk_i;

  blk_prot_table u_blk_prot_table (.*);

  task automatic m_reset();
    for (int k = 0; k < 32; k++) begin m_rp[k] = 0; m_wp[k] = 1; m_lk[k] = 0; end
    m_idx[0] = 0; m_idx[1] = 0;
  endtask

  function automatic logic [7:0] exp_rd(int b);
    int k = b * 16 + m_idx[b];
    return {4'(m_idx[b]), 1'b0, 1'(m_lk[k]), 1'(m_wp[k]), 1'(m_rp[k])};
  endfunction

  function automatic logic exp_allow();
    int k;
    bit rok, wok;
    if (acc_addr_i >= 24'h20_0000) return 1'b0;
    k = int'(acc_addr_i) / 65536;
    rok = !m_rp[k] && !core_rd_deny_i;
    wok = !m_wp[k] && !core_wr_deny_i;
    return (acc_rd_i || acc_wr_i) && (!acc_rd_i || rok) && (!acc_wr_i || wok);
  endfunction

  task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // drive after negedge, compare mid-cycle, update model at posedge
  task automatic step(bit we, bit sel, logic [7:0] wd, logic [23:0] a,
                      bit rd, bit wr, bit crd, bit cwr);
    int k;
    reg_we_i = we; reg_sel_i = sel; reg_wdata_i = wd;
    acc_addr_i = a; acc_rd_i = rd; acc_wr_i = wr;
    core_rd_deny_i = crd; core_wr_deny_i = cwr;
    #1;
    chk(reg_rdata_o == exp_rd(sel), "R2 readback", reg_rdata_o, exp_rd(sel));
    chk(reg_rdata_o[3] == 1'b0, "R5 bit3", reg_rdata_o, {4'h0, 1'b0, 3'h0});
    chk(acc_allow_o == exp_allow(), "R8/R9 allow", 8'(acc_allow_o), 8'(exp_allow()));
    @(posedge clk_i);
    if (we) begin
      m_idx[sel] = int'(wd[7:4]);
      if (!wd[3]) begin
        k = sel * 16 + m_idx[sel];
        if (!m_lk[k]) begin m_rp[k] = wd[0]; m_wp[k] = wd[1]; m_lk[k] = wd[2]; end
      end
    end
    @(negedge clk_i);
  endtask

  task automatic idle(bit sel);
    step(0, sel, 8'h00, 24'h0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    m_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: walk every block through index-only writes
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 16; i++) begin
        step(1, b[0], {4'(i), 4'b1000}, 24'h0, 0, 0, 0, 0);
        #1 chk(reg_rdata_o == {4'(i), 4'b0010}, "R1 reset flags", reg_rdata_o, {4'(i), 4'b0010});
        @(negedge clk_i);
      end
    // R3: full write to block 5, then access checks
    step(1, 0, 8'h51, 24'h0, 0, 0, 0, 0);
    idle(0);
    #1 chk(reg_rdata_o == 8'h51, "R3 full write", reg_rdata_o, 8'h51);
    @(negedge clk_i);
    step(0, 0, 0, 24'h05_1234, 1, 0, 0, 0);
    #1 chk(acc_allow_o == 1'b0, "R8 read inhibited", 8'(acc_allow_o), 8'h0);
    @(negedge clk_i);
    step(0, 0, 0, 24'h05_1234, 0, 1, 0, 0);
    #1 chk(acc_allow_o == 1'b1, "R8 write allowed", 8'(acc_allow_o), 8'h1);
    @(negedge clk_i);
    step(0, 0, 0, 24'h05_1234, 0, 1, 0, 1);
    #1 chk(acc_allow_o == 1'b0, "R8 core write deny", 8'(acc_allow_o), 8'h0);
    @(negedge clk_i);
    // R4: index-only write carrying flag bits
    step(1, 0, 8'h5F, 24'h0, 0, 0, 0, 0);
    idle(0);
    #1 chk(reg_rdata_o == 8'h51, "R4 index only", reg_rdata_o, 8'h51);
    @(negedge clk_i);
    // R7: second register pointer separate
    step(1, 1, 8'h38, 24'h0, 0, 0, 0, 0);
    idle(0);
    #1 chk(reg_rdata_o[7:4] == 4'h5, "R7 own index", reg_rdata_o, 8'h51);
    @(negedge clk_i);
    // R6: lock block 20 open, then try to change it
    step(1, 1, 8'h44, 24'h0, 0, 0, 0, 0);
    step(1, 1, 8'h43, 24'h0, 0, 0, 0, 0);
    idle(1);
    #1 chk(reg_rdata_o == 8'h44, "R6 lock freeze", reg_rdata_o, 8'h44);
    @(negedge clk_i);
    step(0, 1, 0, 24'h14_0000, 1, 1, 0, 0);
    #1 chk(acc_allow_o == 1'b1, "R8 rd+wr allowed", 8'(acc_allow_o), 8'h1);
    @(negedge clk_i);
    // R9: out of range
    step(0, 1, 0, 24'h34_0000, 1, 1, 0, 0);
    #1 chk(acc_allow_o == 1'b0, "R9 above 2M", 8'(acc_allow_o), 8'h0);
    @(negedge clk_i);
    // mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [7:0] wd;
      logic [23:0] a;
      wd = 8'($urandom);
      wd[2] = ($urandom % 10 == 0);
      a = ($urandom % 4 == 0) ? 24'($urandom) : 24'($urandom % 24'h20_0000);
      step(($urandom % 3) == 0, 1'($urandom), wd, a, 1'($urandom), 1'($urandom),
           ($urandom % 4) == 0, ($urandom % 4) == 0);
    end
    // R6: reset clears the lock on block 20
    do_reset();
    step(1, 1, 8'h48, 24'h0, 0, 0, 0, 0);
    idle(1);
    #1 chk(reg_rdata_o == 8'h42, "R6 reset clears lock", reg_rdata_o, 8'h42);
    @(negedge clk_i);
    step(1, 1, 8'h41, 24'h0, 0, 0, 0, 0);
    idle(1);
    #1 chk(reg_rdata_o == 8'h41, "R6 writable after reset", reg_rdata_o, 8'h41);
    @(negedge clk_i);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule